// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Software Refill

This block caches virtual-to-physical page translations for a processor whose page tables are walked by a trap handler rather than by hardware. Any translation may sit in any slot. A lookup compares the page field of the presented virtual address and the current address-space tag against every slot at once. One cycle later the block reports exactly one of three outcomes: a hit with the physical address, a protection fault, or a miss. On a miss the block only signals the exception, so software can walk its own table and refill.

Privileged inputs load a translation, set the current address-space tag, write the page-table base register and flush the buffer. A write to the page-table base register also flushes. Because every slot carries an address-space tag, translations of different processes can be held side by side, including identical page/frame pairs shared between processes. A small group of low-index slots can be pinned. Pinned slots survive flushes and are never chosen for replacement, so the miss handler's own pages cannot miss.

Top module: `asid_tlb`

## Requirements
- R1: The slot count `ENTRIES` is a parameter, and a translation can be found in whichever slot it was loaded into. Every slot takes part in each lookup.
- R2: A lookup hits only on a valid slot whose page number equals `lk_va[VA_W-1:PG_OFS]` and whose tag equals the current address-space register. A matching page with a different tag misses.
- R3: On a permitted hit, `rsp_pa` equals the slot's frame number followed by the untouched low `PG_OFS` bits of `lk_va`.
- R4: Access codes are 0 read, 1 write, 2 execute, and 3 is never allowed. Protection bits are bit 0 read, bit 1 write, bit 2 execute. On a hit whose bit for the requested access is clear, `rsp_fault` is raised and `rsp_pa` is zero.
- R5: A lookup with no matching slot raises only `rsp_miss`, with `rsp_pa` zero, and changes no slot.
- R6: A pulse on `flush` invalidates every slot with index `WIRED` or above.
- R7: A pulse on `ptbr_we` loads `ptbr`, which is visible on the next cycle, and invalidates the same slots as a flush.
- R8: Two slots with the same page and frame but different tags both stay valid, and each hits while its own tag is current.
- R9: A refill with `fill_wired` set writes slot `fill_slot` when that index is below `WIRED`, and has no effect otherwise. Slots below `WIRED` are never cleared by a flush or chosen as a refill victim.
- R10: A normal refill writes the slot under a round-robin pointer. The pointer starts at `WIRED` after reset, advances by one per such refill and wraps from `ENTRIES-1` back to `WIRED`.
- R11: A refill whose page and tag match a valid slot overwrites that slot and does not move the pointer, so no two valid slots ever match one lookup.
- R12: `rsp_valid` follows `lk_valid` one cycle later, with exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` set. All response outputs are zero when no response is due and after reset.
- R13: A lookup sees the slots and the address-space tag as they were before any refill, tag write or flush issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_acc | input | 2 | Access type (0 read, 1 write, 2 execute) |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_hit | output | 1 | Permitted hit |
| rsp_miss | output | 1 | No matching translation |
| rsp_fault | output | 1 | Hit with the access forbidden |
| rsp_pa | output | PA_W | Physical address on a permitted hit, else zero |
| fill_en | input | 1 | Refill strobe (privileged) |
| fill_vpn | input | VPN_W | Page number to load |
| fill_pfn | input | PFN_W | Frame number to load |
| fill_prot | input | 3 | Protection bits {x, w, r} |
| fill_asid | input | ASID_W | Address-space tag of the translation |
| fill_wired | input | 1 | Load into the pinned slot given by fill_slot |
| fill_slot | input | IDX_W | Pinned slot index |
| asid_we | input | 1 | Write the current address-space register |
| asid_wdata | input | ASID_W | New current tag |
| ptbr_we | input | 1 | Write the page-table base register (also flushes) |
| ptbr_wdata | input | PA_W | New page-table base |
| ptbr | output | PA_W | Page-table base register |
| flush | input | 1 | Invalidate all non-pinned slots |

## Verification
The bench builds the block with eight slots, two of them pinned, 8-bit page and frame numbers, a 4-bit offset and 4-bit tags. At that size six normal refills wrap the victim pointer once, so its skip over the pinned slots and the eviction of older translations are reached within a handful of cycles. Every slot is filled and looked up. Pinned slots are then shown to survive both kinds of flush, and same-cycle refill and tag writes are shown not to disturb a lookup issued alongside them.

// File: rtl/tlb_pkg.sv
// Shared definitions for the tagged translation buffer.
// Assumes protection bits are ordered {execute, write, read}.
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    localparam int PROT_W = 3;

    // Returns 1 when the protection bits permit the access type.
    function automatic logic prot_allows(input logic [PROT_W-1:0] prot, input acc_e acc);
        case (acc)
            ACC_READ:  return prot[0];
            ACC_WRITE: return prot[1];
            ACC_EXEC:  return prot[2];
            default:   return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tlb_cam.sv
// Slot storage and parallel compare for the translation buffer.
// Each slot holds page, frame, protection, tag and a valid bit. The lookup
// port returns the frame and protection of the single matching slot. The fill
// port reports whether a valid slot already holds the fill's page and tag.
// Assumes the caller never creates two valid slots with the same page and tag.
module tlb_cam #(
    parameter int ENTRIES = 32,
    parameter int WIRED   = 2,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [VPN_W-1:0]          lk_vpn,
    input  logic [ASID_W-1:0]         lk_asid,
    output logic                      lk_hit,
    output logic [PFN_W-1:0]          lk_pfn,
    output logic [tlb_pkg::PROT_W-1:0] lk_prot,
    input  logic [VPN_W-1:0]          fl_vpn,
    input  logic [ASID_W-1:0]         fl_asid,
    output logic                      fl_match,
    output logic [IDX_W-1:0]          fl_idx,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [PFN_W-1:0]          wr_pfn,
    input  logic [tlb_pkg::PROT_W-1:0] wr_prot,
    input  logic                      clear
);
    logic                       valid_q [ENTRIES];
    logic [VPN_W-1:0]           vpn_q   [ENTRIES];
    logic [PFN_W-1:0]           pfn_q   [ENTRIES];
    logic [tlb_pkg::PROT_W-1:0] prot_q  [ENTRIES];
    logic [ASID_W-1:0]          tag_q   [ENTRIES];
    logic [ENTRIES-1:0]         lk_match;
    logic [ENTRIES-1:0]         fl_hitvec;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        localparam bit PINNED = (i < WIRED);

        // Valid bit: set on write, cleared by a flush unless the slot is pinned.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                valid_q[i] <= 1'b1;
            end else if (clear && !PINNED) begin
                valid_q[i] <= 1'b0;
            end
        end

        // Translation payload: loaded on write, no reset needed.
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                vpn_q[i]  <= fl_vpn;
                pfn_q[i]  <= wr_pfn;
                prot_q[i] <= wr_prot;
                tag_q[i]  <= fl_asid;
            end
        end

        assign lk_match[i]  = valid_q[i] && vpn_q[i] == lk_vpn && tag_q[i] == lk_asid;
        assign fl_hitvec[i] = valid_q[i] && vpn_q[i] == fl_vpn && tag_q[i] == fl_asid;

        if (PINNED) begin : g_pin_chk
            assert_pinned_stays_R9: assert property (@(posedge clk) disable iff (!rst_n)
                valid_q[i] |=> valid_q[i]);
        end
    end

    // Lookup mux: OR of the (at most one) matching slot.
    always_comb begin
        lk_hit  = 1'b0;
        lk_pfn  = '0;
        lk_prot = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (lk_match[k]) begin
                lk_hit  = 1'b1;
                lk_pfn  = lk_pfn | pfn_q[k];
                lk_prot = lk_prot | prot_q[k];
            end
        end
    end

    // Fill-side duplicate detection: index of the lowest matching slot.
    always_comb begin
        fl_match = 1'b0;
        fl_idx   = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (fl_hitvec[k] && !fl_match) begin
                fl_match = 1'b1;
                fl_idx   = IDX_W'(k);
            end
        end
    end

    // Valid bits of the slots a flush may clear.
    logic loose_valid;
    always_comb begin
        loose_valid = 1'b0;
        for (int k = WIRED; k < ENTRIES; k++) loose_valid = loose_valid | valid_q[k];
    end

    assert_single_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !wr_en) |=> !loose_valid);
endmodule

// File: rtl/tlb_victim.sv
// Round-robin replacement pointer over the unpinned slots.
// Steps through WIRED .. ENTRIES-1 and wraps. Assumes WIRED < ENTRIES.
module tlb_victim #(
    parameter int ENTRIES = 32,
    parameter int WIRED   = 2,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);
    // Pointer update: one step per consumed victim, wrapping past the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= IDX_W'(WIRED);
        end else if (advance) begin
            ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? IDX_W'(WIRED) : ptr + 1'b1;
        end
    end

    assert_ptr_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ptr) >= WIRED) && (int'(ptr) < ENTRIES));
endmodule

// File: rtl/asid_tlb.sv
// Fully associative, address-space-tagged translation buffer with software refill.
// A lookup is answered one cycle later with hit, miss or protection fault.
// Privileged inputs refill slots, set the current tag, write the page-table
// base (which flushes) and flush. Slots below WIRED are pinned.
// Assumes 2 <= ENTRIES and WIRED < ENTRIES.
module asid_tlb #(
    parameter int ENTRIES = 32,
    parameter int WIRED   = 2,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20,
    parameter int PG_OFS  = 12,
    parameter int ASID_W  = 8,
    localparam int VA_W   = VPN_W + PG_OFS,
    localparam int PA_W   = PFN_W + PG_OFS,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [1:0]        lk_acc,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_fault,
    output logic [PA_W-1:0]   rsp_pa,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [2:0]        fill_prot,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_wired,
    input  logic [IDX_W-1:0]  fill_slot,
    input  logic              asid_we,
    input  logic [ASID_W-1:0] asid_wdata,
    input  logic              ptbr_we,
    input  logic [PA_W-1:0]   ptbr_wdata,
    output logic [PA_W-1:0]   ptbr,
    input  logic              flush
);
    import tlb_pkg::*;

    logic [ASID_W-1:0] cur_asid;
    logic              hit_c;
    logic [PFN_W-1:0]  pfn_c;
    logic [PROT_W-1:0] prot_c;
    logic              dup_c;
    logic [IDX_W-1:0]  dup_idx;
    logic [IDX_W-1:0]  victim;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic              take_victim;
    logic              allow_c;

    // Write target: duplicate slot first, then pinned slot, then victim.
    always_comb begin
        take_victim = fill_en && !dup_c && !fill_wired;
        wr_en       = fill_en && (dup_c || !fill_wired || int'(fill_slot) < WIRED);
        if (dup_c)           wr_idx = dup_idx;
        else if (fill_wired) wr_idx = fill_slot;
        else                 wr_idx = victim;
    end

    assign allow_c = prot_allows(prot_c, acc_e'(lk_acc));

    tlb_cam #(
        .ENTRIES(ENTRIES), .WIRED(WIRED), .VPN_W(VPN_W),
        .PFN_W(PFN_W), .ASID_W(ASID_W), .IDX_W(IDX_W)
    ) u_cam (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_va[VA_W-1:PG_OFS]), .lk_asid(cur_asid),
        .lk_hit(hit_c), .lk_pfn(pfn_c), .lk_prot(prot_c),
        .fl_vpn(fill_vpn), .fl_asid(fill_asid),
        .fl_match(dup_c), .fl_idx(dup_idx),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_pfn(fill_pfn), .wr_prot(fill_prot),
        .clear(flush || ptbr_we)
    );

    tlb_victim #(.ENTRIES(ENTRIES), .WIRED(WIRED), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .advance(take_victim), .ptr(victim)
    );

    // Privileged registers: current address-space tag and page-table base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_asid <= '0;
            ptbr     <= '0;
        end else begin
            if (asid_we) cur_asid <= asid_wdata;
            if (ptbr_we) ptbr     <= ptbr_wdata;
        end
    end

    // Response register: classify the lookup and form the physical address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && hit_c && allow_c;
            rsp_fault <= lk_valid && hit_c && !allow_c;
            rsp_miss  <= lk_valid && !hit_c;
            rsp_pa    <= (lk_valid && hit_c && allow_c) ? {pfn_c, lk_va[PG_OFS-1:0]} : '0;
        end
    end

    assert_one_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);
    assert_quiet_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault) && rsp_pa == '0);
    assert_strobe_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    assert_pa_only_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> rsp_pa == '0);
    assert_ptbr_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ptbr_we |=> ptbr == $past(ptbr_wdata));
endmodule

// File: tb/asid_tlb_test.sv
// Bench: behavioural reference model compared every cycle, plus directed checks.
module asid_tlb_test;
    localparam int ENT = 8, WIR = 2, VPNW = 8, PFNW = 8, OFS = 4, AW = 4;
    localparam int VAW = VPNW + OFS, PAW = PFNW + OFS, IW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 0; logic [VAW-1:0] lk_va = '0; logic [1:0] lk_acc = '0;
    logic rsp_valid, rsp_hit, rsp_miss, rsp_fault; logic [PAW-1:0] rsp_pa;
    logic fill_en = 0; logic [VPNW-1:0] fill_vpn = '0; logic [PFNW-1:0] fill_pfn = '0;
    logic [2:0] fill_prot = '0; logic [AW-1:0] fill_asid = '0;
    logic fill_wired = 0; logic [IW-1:0] fill_slot = '0;
    logic asid_we = 0; logic [AW-1:0] asid_wdata = '0;
    logic ptbr_we = 0; logic [PAW-1:0] ptbr_wdata = '0; logic [PAW-1:0] ptbr;
    logic flush = 0;

    int checks = 0, errors = 0;
    bit started = 0, done = 0;

    always #4 clk = ~clk;

    asid_tlb #(.ENTRIES(ENT), .WIRED(WIR), .VPN_W(VPNW), .PFN_W(PFNW),
               .PG_OFS(OFS), .ASID_W(AW)) uut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Reference model state
    bit m_v [ENT]; int m_vpn [ENT]; int m_pfn [ENT]; int m_prot [ENT]; int m_tag [ENT];
    int m_ptr, m_asid, m_ptbr;
    bit e_valid; int e_kind, e_pa;   // kind: 0 miss, 1 hit, 2 fault

    function automatic bit permits(int prot, int acc);
        if (acc > 2) return 0;
        return prot[acc];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_v[k]) m_v[k] = 0;
            m_ptr = WIR; m_asid = 0; m_ptbr = 0; e_valid = 0; e_kind = 0; e_pa = 0;
        end else begin
            int hitk, dup, slot;
            hitk = -1; dup = -1; slot = -1;
            e_valid = lk_valid; e_kind = 0; e_pa = 0;
            foreach (m_v[k]) begin
                if (m_v[k] && m_vpn[k] == int'(lk_va[VAW-1:OFS]) && m_tag[k] == m_asid) hitk = k;
                if (m_v[k] && m_vpn[k] == int'(fill_vpn) && m_tag[k] == int'(fill_asid)) dup = k;
            end
            if (hitk >= 0) begin
                if (permits(m_prot[hitk], int'(lk_acc))) begin
                    e_kind = 1; e_pa = m_pfn[hitk] * 16 + int'(lk_va[OFS-1:0]);
                end else e_kind = 2;
            end
            if (asid_we) m_asid = int'(asid_wdata);
            if (ptbr_we) m_ptbr = int'(ptbr_wdata);
            if (flush || ptbr_we) for (int k = WIR; k < ENT; k++) m_v[k] = 0;
            if (fill_en) begin
                if (dup >= 0) slot = dup;
                else if (fill_wired) begin
                    if (int'(fill_slot) < WIR) slot = int'(fill_slot);
                end else begin
                    slot = m_ptr;
                    m_ptr = (m_ptr == ENT - 1) ? WIR : m_ptr + 1;
                end
                if (slot >= 0) begin
                    m_v[slot] = 1; m_vpn[slot] = int'(fill_vpn); m_pfn[slot] = int'(fill_pfn);
                    m_prot[slot] = int'(fill_prot); m_tag[slot] = int'(fill_asid);
                end
            end
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (started) begin
            int got;
            got = {29'd0, rsp_hit, rsp_miss, rsp_fault};
            if (!e_valid)
                check(!rsp_valid && got == 0 && rsp_pa == 0, "R12 idle response", got, 0);
            else if (e_kind == 1)
                check(rsp_valid && got == 4 && int'(rsp_pa) == e_pa, "R3 model hit address",
                      int'(rsp_pa), e_pa);
            else if (e_kind == 2)
                check(rsp_valid && got == 1 && rsp_pa == 0, "R4 model fault", got, 1);
            else
                check(rsp_valid && got == 2 && rsp_pa == 0, "R5 model miss", got, 2);
            check(int'(ptbr) == m_ptbr, "R7 model base register", int'(ptbr), m_ptbr);
        end
    end

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic look(input int va, input int acc, input string tag, input int kind, input int pa);
        lk_valid = 1; lk_va = VAW'(va); lk_acc = 2'(acc);
        @(negedge clk);
        lk_valid = 0;
        check(rsp_valid && rsp_hit == (kind == 1) && rsp_miss == (kind == 0) &&
              rsp_fault == (kind == 2) && int'(rsp_pa) == pa, tag,
              {rsp_hit, rsp_miss, rsp_fault} * 4096 + int'(rsp_pa),
              (kind == 1 ? 4 : kind == 0 ? 2 : 1) * 4096 + pa);
    endtask

    task automatic fill(input int vpn, input int pfn, input int prot, input int asid,
                        input bit pin, input int slot);
        fill_en = 1; fill_vpn = VPNW'(vpn); fill_pfn = PFNW'(pfn); fill_prot = 3'(prot);
        fill_asid = AW'(asid); fill_wired = pin; fill_slot = IW'(slot);
        @(negedge clk);
        fill_en = 0; fill_wired = 0;
    endtask

    task automatic set_asid(input int a);
        asid_we = 1; asid_wdata = AW'(a);
        @(negedge clk);
        asid_we = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        check(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_fault && rsp_pa == 0 && ptbr == 0,
              "R12 reset state", int'(rsp_pa), 0);
        started = 1;

        look(12'h123, 0, "R5 empty buffer miss", 0, 0);
        set_asid(1);
        fill(8'h12, 8'hA5, 3'b001, 1, 0, 0);
        look(12'h123, 0, "R3 read hit address", 1, 12'hA53);
        look(12'h123, 1, "R4 write forbidden", 2, 0);
        look(12'h12F, 2, "R4 execute forbidden", 2, 0);
        look(12'h12F, 3, "R4 access code 3 never allowed", 2, 0);

        fill(8'h12, 8'hA5, 3'b101, 2, 0, 0);
        set_asid(2);
        look(12'h125, 2, "R8 shared page second tag", 1, 12'hA55);
        set_asid(1);
        look(12'h125, 0, "R8 shared page first tag", 1, 12'hA55);
        look(12'h125, 2, "R8 first tag keeps own rights", 2, 0);
        set_asid(3);
        look(12'h125, 0, "R2 tag mismatch misses", 0, 0);
        set_asid(1);

        fill(8'h12, 8'h3C, 3'b111, 1, 0, 0);
        look(12'h127, 1, "R11 duplicate overwritten in place", 1, 12'h3C7);
        set_asid(2);
        look(12'h125, 0, "R11 other tag untouched", 1, 12'hA55);
        set_asid(1);

        for (int k = 0; k < 6; k++) fill(8'h40 + k, 8'h60 + k, 3'b111, 1, 0, 0);
        look(12'h123, 0, "R10 pointer wrapped and evicted oldest", 0, 0);
        for (int k = 0; k < 6; k++)
            look(12'h401 + k * 16, 0, "R1 every unpinned slot holds a translation", 1,
                 (12'h601 + k * 16));

        lk_valid = 1; lk_va = 12'h402; lk_acc = 0; asid_we = 1; asid_wdata = 4'd2;
        @(negedge clk);
        lk_valid = 0; asid_we = 0;
        check(rsp_hit && int'(rsp_pa) == 12'h602, "R13 lookup uses old tag", int'(rsp_pa), 12'h602);
        look(12'h402, 0, "R13 new tag in force next cycle", 0, 0);
        set_asid(1);

        lk_valid = 1; lk_va = 12'h7A3; lk_acc = 0;
        fill_en = 1; fill_vpn = 8'h7A; fill_pfn = 8'h99; fill_prot = 3'b001; fill_asid = 4'd1;
        @(negedge clk);
        lk_valid = 0; fill_en = 0;
        check(rsp_miss, "R13 same-cycle refill not seen", int'(rsp_miss), 1);
        look(12'h7A3, 0, "R13 refill visible afterwards", 1, 12'h993);

        fill(8'hF0, 8'h11, 3'b100, 1, 1, 0);
        fill(8'hF1, 8'h12, 3'b001, 1, 1, 1);
        fill(8'hE0, 8'h13, 3'b001, 1, 1, 5);
        look(12'hE00, 0, "R9 pinned fill beyond range ignored", 0, 0);
        for (int k = 0; k < 8; k++) fill(8'h50 + k, 8'h70 + k, 3'b001, 1, 0, 0);
        look(12'hF04, 2, "R9 pinned slot never a victim", 1, 12'h114);
        look(12'hF13, 0, "R9 second pinned slot kept", 1, 12'h123);

        flush = 1; idle(); flush = 0;
        look(12'h571, 0, "R6 flush clears unpinned", 0, 0);
        look(12'hF04, 2, "R9 pinned survives flush", 1, 12'h114);

        fill(8'h58, 8'h20, 3'b001, 1, 0, 0);
        look(12'h580, 0, "R10 refill after flush", 1, 12'h200);
        ptbr_we = 1; ptbr_wdata = 12'h5A5; idle(); ptbr_we = 0;
        check(ptbr == 12'h5A5, "R7 base register loaded", int'(ptbr), 12'h5A5);
        look(12'h580, 0, "R7 base write flushes", 0, 0);
        look(12'hF13, 0, "R9 pinned survives base write", 1, 12'h123);

        idle(); idle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule